// File: doc/BRIEF.md
# Pipelined Byte-Masked Synchronous SRAM

This block is a single-port synchronous memory with a register stage on every input and a second register stage in front of the read data. It serves as an on-chip word store or as a cycle-accurate memory model. Each clock edge captures an address, a write word, the write controls and three chip-select inputs of mixed polarity. A write lands in the array one edge after capture. A read word reaches the output two edges after capture.

The word is split into byte lanes of nine bits each: eight data bits and one parity bit. A global write input stores the whole word. Otherwise a master lane-write enable together with a per-lane enable selects which lanes are stored. Any captured cycle that is selected and stores no lane is a read. The output drive flag comes from the read pipeline and is gated combinationally by an asynchronous output enable. Burst address sequencing is handled outside the block.

Top module: `pbw_sram`

## Requirements
- R1: All inputs except `oe_n` are sampled on the rising clock edge. Read data captured at edge k appears on `rdata` with `rdata_en` high after edge k+1, which is a latency of two edges.
- R2: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A cycle that is not selected writes nothing.
- R3: When `gw_n`=0 in a selected cycle, all lanes are written, whatever `lw_en_n` and `lane_n` hold.
- R4: When `gw_n`=1 and `lw_en_n`=0, lane i is written if and only if `lane_n[i]`=0. Lane i occupies bits 9i+8 down to 9i of the word, and lane 0 is the least significant.
- R5: A selected cycle that writes no lane is a read: either `gw_n`=1 and `lw_en_n`=1, or `gw_n`=1 and every `lane_n` bit is 1. Such a cycle leaves the array unchanged.
- R6: A read of an address captured on the edge after a write to that address returns the newly written lanes merged with the old unwritten lanes.
- R7: A deselected or write cycle captured at edge k makes `rdata_en` low after edge k+1. Deselection therefore takes effect in a single cycle.
- R8: `oe_n`=1 forces `rdata_en` low without waiting for a clock. While `rdata_en` is low, `rdata` reads all zero, which stands for high impedance.
- R9: After reset is asserted, `rdata_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write word |
| lane_n | input | LANES | Per-lane write enables, active low |
| lw_en_n | input | 1 | Master enable for the per-lane writes, active low |
| gw_n | input | 1 | Whole-word write, active low |
| sel_a_n | input | 1 | Chip select used for address pipelining, active low |
| sel_b | input | 1 | Depth-expansion select, active high |
| sel_c_n | input | 1 | Depth-expansion select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read word, zero when not driven |
| rdata_en | output | 1 | Output drive flag |

## Verification
Two functions can fall in the same cycle. In the array, the write of one captured request meets the read of the next request on the same edge. At the output, the asynchronous output-enable gating meets the pipelined deselect. The first overlap is provoked by back-to-back write-then-read pairs to one address, with partial lane masks, so that a stale or unmerged word shows up as a lane mismatch against a bench-side word model. The second is provoked by toggling `oe_n` between clock edges while a read result is held, and by placing a deselect directly after a read. In both cases `rdata_en` and `rdata` are compared with the values the bench predicts.

// File: rtl/pbw_sram_pkg.sv
package pbw_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // chip is active only for the one select combination low-high-low
  function automatic logic chip_on(input logic a_n, input logic b, input logic c_n);
    return (!a_n) && b && (!c_n);
  endfunction

endpackage

// File: rtl/pbw_in_stage.sv
module pbw_in_stage
  import pbw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_n,
  input  logic              lw_en_n,
  input  logic              gw_n,
  input  logic              chip_sel,
  output op_e               op_q,
  output logic [LANES-1:0]  mask_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  // lanes to be stored: whole word on global write, else qualified lane enables
  function automatic logic [LANES-1:0] lane_select(input logic g_n, input logic m_n,
                                                   input logic [LANES-1:0] l_n);
    if (!g_n)      return '1;
    else if (!m_n) return ~l_n;
    else           return '0;
  endfunction

  logic [LANES-1:0] mask_d;
  op_e              op_d;

  always_comb begin
    mask_d = lane_select(gw_n, lw_en_n, lane_n);
    if (!chip_sel)        op_d = OP_IDLE;
    else if (|mask_d)     op_d = OP_WRITE;
    else                  op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= op_d;
      mask_q  <= chip_sel ? mask_d : '0;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // R3: a selected global write records every lane
  a_r3_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !gw_n) |=> (&mask_q && op_q == OP_WRITE));

  // R4: per-lane record follows the inverted lane inputs
  a_r4_lane_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && gw_n && !lw_en_n) |=> (mask_q == ~$past(lane_n)));

  // R5: no write control active -> read with empty mask
  a_r5_read_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && gw_n && lw_en_n) |=> (mask_q == '0 && op_q == OP_READ));

endmodule

// File: rtl/pbw_array.sv
module pbw_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rd_word[i*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/pbw_out_stage.sv
module pbw_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);

  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= rd_fire;
      if (rd_fire) dat_q <= rd_word;
    end
  end

  assign rdata_en = vld_q & ~oe_n;
  assign rdata    = rdata_en ? dat_q : '0;

  // R8: a read result is driven exactly when the output enable is low
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rdata_en == !oe_n));

  // R1: held word keeps its value while no read is launched
  a_r1_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(dat_q));

endmodule

// File: rtl/pbw_sram.sv
module pbw_sram
  import pbw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_n,
  input  logic              lw_en_n,
  input  logic              gw_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);

  logic              chip_sel;
  op_e               op_q;
  logic [LANES-1:0]  mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  lane_we;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_word;

  assign chip_sel = chip_on(sel_a_n, sel_b, sel_c_n);

  pbw_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .lane_n(lane_n),
    .lw_en_n(lw_en_n), .gw_n(gw_n), .chip_sel(chip_sel),
    .op_q(op_q), .mask_q(mask_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  assign lane_we = (op_q == OP_WRITE) ? mask_q : '0;
  assign rd_fire = (op_q == OP_READ);

  pbw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(addr_q), .lane_we(lane_we), .wdata(wdata_q), .rd_word(rd_word)
  );

  pbw_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_word(rd_word), .oe_n(oe_n),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  // R2: an unselected cycle never reaches the array as a write
  a_r2_no_write_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> (lane_we == '0 && !rd_fire));

  // R7: deselect removes the drive one cycle later
  a_r7_single_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> ##1 !rdata_en);

  // R9: drive flag is clear while reset is applied
  always_comb begin
    if (!rst_n) a_r9_reset_quiet: assert (!rdata_en);
  end

endmodule

// File: tb/test_pbw_sram.sv
module test_pbw_sram;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [LANES-1:0]  lane_n = '1;
  logic lw_en_n = 1'b1, gw_n = 1'b1;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic oe_n = 1'b0;
  logic [DATA_W-1:0] rdata;
  logic rdata_en;

  always #2.5 clk = ~clk;

  pbw_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_pbw_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .lane_n(lane_n),
    .lw_en_n(lw_en_n), .gw_n(gw_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en)
  );

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] exp_d [2];
  logic              exp_v [2];
  string             exp_t [2];

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // bench view of the written lanes (restated as a per-bit loop)
  function automatic logic [DATA_W-1:0] bit_mask(input logic g_n, input logic m_n,
                                                 input logic [LANES-1:0] l_n);
    logic [DATA_W-1:0] m = '0;
    for (int b = 0; b < DATA_W; b++)
      m[b] = (g_n == 1'b0) || (m_n == 1'b0 && l_n[b / LANE_W] == 1'b0);
    return m;
  endfunction

  // one bus cycle: check the result of the op two steps back, then drive a new op
  task automatic step(input bit sel_ok, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic g_n, input logic m_n,
                      input logic [LANES-1:0] l_n, input string tag, input bit oe_probe);
    logic [DATA_W-1:0] m;
    string t;
    @(negedge clk);
    if (oe_probe) begin
      oe_n = 1'b1; #0.5;
      check("R8 drive off", {35'd0, rdata_en}, '0);
      check("R8 data zero", rdata, '0);
      oe_n = 1'b0; #0.5;
    end
    check({exp_t[1], " en"}, {35'd0, rdata_en}, {35'd0, exp_v[1]});
    if (exp_v[1]) check({exp_t[1], " data"}, rdata, exp_d[1]);
    exp_v[1] = exp_v[0]; exp_d[1] = exp_d[0]; exp_t[1] = exp_t[0];
    addr = a; wdata = d; gw_n = g_n; lw_en_n = m_n; lane_n = l_n;
    if (sel_ok) begin sel_a_n = 0; sel_b = 1; sel_c_n = 0; end
    else begin
      case ($urandom_range(2, 0))
        0: begin sel_a_n = 1; sel_b = 1; sel_c_n = 0; end
        1: begin sel_a_n = 0; sel_b = 0; sel_c_n = 0; end
        default: begin sel_a_n = 0; sel_b = 1; sel_c_n = 1; end
      endcase
    end
    m = bit_mask(g_n, m_n, l_n);
    if (!sel_ok)        t = "R2";
    else if (!g_n)      t = "R3";
    else if (m != '0)   t = "R4";
    else                t = "R5";
    if (tag != "") t = tag;
    exp_t[0] = t;
    if (sel_ok && m != '0) begin
      model[a] = (model[a] & ~m) | (d & m);
      exp_v[0] = 1'b0;
    end else begin
      exp_v[0] = sel_ok;
      exp_d[0] = model[a];
    end
  endtask

  function automatic logic [DATA_W-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 2; k++) begin exp_v[k] = 0; exp_d[k] = '0; exp_t[k] = "R1"; end
    #1;
    check("R9 reset drive", {35'd0, rdata_en}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 after reset", {35'd0, rdata_en}, '0);
    // fill the array with whole-word writes
    for (int a = 0; a < DEPTH; a++)
      step(1, a[ADDR_W-1:0], rnd_word(), 0, 1, '1, "R3", 0);
    // R1 latency: read directly
    step(1, 6'd5, '0, 1, 1, '0, "R1", 0);
    // R3: global write ignores master/lane disables
    step(1, 6'd7, rnd_word(), 0, 1, 4'b1111, "R3", 0);
    step(1, 6'd7, '0, 1, 1, '1, "R3 readback", 0);
    // R5: lane enables low but master disabled -> read, no change
    step(1, 6'd9, rnd_word(), 1, 1, 4'b0000, "R5", 0);
    step(1, 6'd9, '0, 1, 0, 4'b1111, "R5 readback", 0);
    // R6: partial write then read of the same address next cycle
    step(1, 6'd12, rnd_word(), 1, 0, 4'b1010, "R6", 0);
    step(1, 6'd12, '0, 1, 1, '1, "R6", 0);
    step(1, 6'd12, rnd_word(), 1, 0, 4'b0110, "R6", 0);
    step(1, 6'd12, '0, 1, 1, '1, "R6", 0);
    // R7: read followed by deselect, and read followed by write
    step(1, 6'd3, '0, 1, 1, '1, "R7 read", 0);
    step(0, 6'd3, '0, 1, 1, '1, "R7 deselect", 0);
    step(1, 6'd4, '0, 1, 1, '1, "R7 read", 0);
    step(1, 6'd4, rnd_word(), 1, 0, 4'b1110, "R7 write", 0);
    step(1, 6'd4, '0, 1, 1, '1, "R4", 0);
    // R2: deselected write leaves the word intact
    step(0, 6'd20, rnd_word(), 0, 0, '0, "R2", 0);
    step(1, 6'd20, '0, 1, 1, '1, "R2 readback", 0);
    step(1, 6'd21, '0, 1, 1, '1, "R1", 0);
    step(1, 6'd21, '0, 1, 1, '1, "R1", 1);
    // constrained random traffic over a small address window
    for (int i = 0; i < 600; i++) begin
      bit s = ($urandom_range(3, 0) != 0);
      int kind = $urandom_range(9, 0);
      logic g = (kind != 0);
      logic mm = (kind < 5) ? 1'b0 : 1'b1;
      step(s, 6'($urandom_range(7, 0)), rnd_word(), g, mm, 4'($urandom()), "",
           (i % 37) == 36);
    end
    repeat (3) step(1, 6'd0, '0, 1, 1, '1, "R1", 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule